// File: doc/BRIEF.md
# Tagged Receive Character Buffer with Selectable Depth

This block sits between a serial receiver and the CPU read path of a UART. Each time the receiver completes a character, it presents the byte and three per-character error flags: parity error, framing error and line break. The block keeps the byte and its flags together as one entry. The CPU sees the oldest entry at the read port, together with a data-ready flag, a sticky overrun flag and the current fill level.

The block has two run-time modes. Character mode is the mode after reset, and in it the block behaves as a single holding register. Queue mode turns the block into a first-in first-out buffer of `DEPTH` entries, 16 by default.

Entering either mode empties the buffer, and so does a flush strobe. When a character arrives and there is no room for it, the character is dropped and the overrun flag is raised. The flag stays set until the CPU reads the status.

Top module: `rxq_tagged_buf`

## Requirements
- R1: After a synchronous active-low reset, the block is in character mode. The level is 0, data-ready is 0, overrun is 0, and the head data and all three head tags are 0.
- R2: In character mode the block holds at most one entry. A push into an occupied holding register without a pop in the same cycle discards the new character, leaves the stored entry unchanged and sets overrun.
- R3: In queue mode (`fifo_mode_i`=1) up to `DEPTH` entries are stored. They are read out in arrival order, and `level_o` equals the number of stored entries, updated one cycle after the push or pop.
- R4: Every entry keeps its own parity error, framing error and break tags. The tags on `head_perr_o`, `head_ferr_o` and `head_brk_o` always belong to the entry shown on `head_data_o`.
- R5: In queue mode, a push when `DEPTH` entries are stored and no pop occurs sets overrun and discards the incoming character, and the stored contents stay unchanged.
- R6: A push and a pop in the same cycle while the buffer is full (in either mode) remove the head and accept the new character. Overrun is not raised by that push.
- R7: Overrun stays set until a cycle with `status_rd_i`=1, which clears it. If a new overrun event occurs in the same cycle as the status read, overrun stays set.
- R8: A change of `fifo_mode_i` empties the buffer on the next clock edge. Any push or pop presented in that cycle is ignored, and overrun is left as it was.
- R9: `flush_i`=1 empties the buffer on the next clock edge. Any push or pop in that cycle is ignored, and overrun is left as it was.
- R10: A pop on an empty buffer has no effect. While the buffer is empty, the head data and head tags read as 0.
- R11: `data_ready_o` is 1 exactly when `level_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Receiver has a completed character |
| push_data_i | input | 8 | Received character |
| push_perr_i | input | 1 | Parity error flag of the character |
| push_ferr_i | input | 1 | Framing error flag of the character |
| push_brk_i | input | 1 | Break flag of the character |
| pop_i | input | 1 | CPU consumes the head entry |
| fifo_mode_i | input | 1 | 0 selects character mode, 1 selects queue mode |
| flush_i | input | 1 | Empty the buffer |
| status_rd_i | input | 1 | CPU status read, clears overrun |
| head_data_o | output | 8 | Data of the oldest entry |
| head_perr_o | output | 1 | Parity error tag of the oldest entry |
| head_ferr_o | output | 1 | Framing error tag of the oldest entry |
| head_brk_o | output | 1 | Break tag of the oldest entry |
| data_ready_o | output | 1 | At least one entry stored |
| overrun_o | output | 1 | Sticky overrun flag |
| level_o | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
A corrupted read pointer or storage slot shows up on the head data and tags in the very cycle after the push or pop that exposes it, because the head port reads the storage without a register stage. A wrong count shows in `level_o` and `data_ready_o` one cycle after the offending strobe. It also shows later as an early or missing overrun at the capacity boundary.

A latched mode that has drifted from the mode input shows as a buffer that was not emptied, or as a second entry accepted in character mode. The bench compares every port against a behavioural queue model on every clock, so any of these faults is reported at the first cycle it reaches a port.

// File: rtl/rxq_pkg.sv
// Shared types for the tagged receive buffer.
// Assumes an 8-bit character and three per-character error tags.
package rxq_pkg;
    localparam int RXQ_DATA_W = 8;

    typedef struct packed {
        logic [RXQ_DATA_W-1:0] data;
        logic                  perr;
        logic                  ferr;
        logic                  brk;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_ctrl.sv
// Pointer, count, mode and overrun control for the receive buffer.
// Assumes DEPTH >= 2. Capacity is 1 in character mode and DEPTH in queue mode.
// A mode change or flush clears pointers and count and ignores push and pop in that cycle.
module rxq_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             fifo_mode_i,
    input  logic             flush_i,
    input  logic             status_rd_i,
    output logic             wr_en_o,
    output logic [AW-1:0]    wr_ptr_o,
    output logic [AW-1:0]    rd_ptr_o,
    output logic [CNT_W-1:0] count_o,
    output logic             overrun_o
);
    localparam logic [CNT_W-1:0] CAP_QUEUE = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_CHAR  = CNT_W'(1);
    localparam logic [AW-1:0]    LAST_IDX  = AW'(DEPTH - 1);

    logic             mode_q;
    logic [CNT_W-1:0] count_q;
    logic [AW-1:0]    wr_ptr_q;
    logic [AW-1:0]    rd_ptr_q;
    logic             ovr_q;

    logic             clear;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;
    logic             ovf_evt;
    logic [CNT_W-1:0] cap;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    // Decode this cycle's accepted push, pop, clear and overrun event.
    always_comb begin
        clear   = flush_i | (fifo_mode_i != mode_q);
        cap     = mode_q ? CAP_QUEUE : CAP_CHAR;
        full    = (count_q == cap);
        empty   = (count_q == '0);
        do_pop  = pop_i & ~empty & ~clear;
        do_push = push_i & ~clear & (~full | do_pop);
        ovf_evt = push_i & ~clear & full & ~do_pop;
    end

    // Update the latched mode, pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            mode_q <= fifo_mode_i;
            if (clear) begin
                count_q  <= '0;
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
                if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
                case ({do_push, do_pop})
                    2'b10:   count_q <= count_q + CNT_W'(1);
                    2'b01:   count_q <= count_q - CNT_W'(1);
                    default: count_q <= count_q;
                endcase
            end
        end
    end

    // Hold the overrun flag; a new event takes priority over the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)           ovr_q <= 1'b0;
        else if (ovf_evt)     ovr_q <= 1'b1;
        else if (status_rd_i) ovr_q <= 1'b0;
    end

    assign wr_en_o   = do_push;
    assign wr_ptr_o  = wr_ptr_q;
    assign rd_ptr_o  = rd_ptr_q;
    assign count_o   = count_q;
    assign overrun_o = ovr_q;
endmodule

// File: rtl/rxq_store.sv
// Entry storage: DEPTH registers, each holding a byte and its three tags.
// Assumes a single write per cycle; the read is a combinational index by read pointer.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [AW-1:0] wr_ptr_i,
    input  rxq_entry_t wr_entry_i,
    input  logic [AW-1:0] rd_ptr_i,
    output rxq_entry_t rd_entry_o
);
    rxq_entry_t slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rxq_entry_t slot_q;

        // Capture the incoming entry when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                slot_q <= '0;
            else if (wr_en_i && (wr_ptr_i == AW'(i)))  slot_q <= wr_entry_i;
        end

        assign slots[i] = slot_q;
    end

    // Select the entry at the read pointer.
    always_comb begin
        rd_entry_o = slots[rd_ptr_i];
    end
endmodule

// File: rtl/rxq_head.sv
// Read-port presentation: shows the head entry when any entry is stored, zeros otherwise.
// Assumes the count and the read entry come from the same cycle's state.
module rxq_head
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  rxq_entry_t       entry_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [RXQ_DATA_W-1:0] data_o,
    output logic             perr_o,
    output logic             ferr_o,
    output logic             brk_o,
    output logic             ready_o
);
    logic nonempty;

    // Gate the head fields by occupancy.
    always_comb begin
        nonempty = (count_i != '0);
        ready_o  = nonempty;
        data_o   = nonempty ? entry_i.data : '0;
        perr_o   = nonempty & entry_i.perr;
        ferr_o   = nonempty & entry_i.ferr;
        brk_o    = nonempty & entry_i.brk;
    end
endmodule

// File: rtl/rxq_tagged_buf.sv
// Top of the tagged receive buffer: single holding register or DEPTH-entry queue.
// Assumes DEPTH >= 2 and one push and one pop strobe per cycle at most.
module rxq_tagged_buf
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic [RXQ_DATA_W-1:0] push_data_i,
    input  logic                  push_perr_i,
    input  logic                  push_ferr_i,
    input  logic                  push_brk_i,
    input  logic                  pop_i,
    input  logic                  fifo_mode_i,
    input  logic                  flush_i,
    input  logic                  status_rd_i,
    output logic [RXQ_DATA_W-1:0] head_data_o,
    output logic                  head_perr_o,
    output logic                  head_ferr_o,
    output logic                  head_brk_o,
    output logic                  data_ready_o,
    output logic                  overrun_o,
    output logic [CNT_W-1:0]      level_o
);
    logic             wr_en;
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CNT_W-1:0] count;
    rxq_entry_t       wr_entry;
    rxq_entry_t       rd_entry;

    // Pack the receiver's character and flags into one entry.
    always_comb begin
        wr_entry.data = push_data_i;
        wr_entry.perr = push_perr_i;
        wr_entry.ferr = push_ferr_i;
        wr_entry.brk  = push_brk_i;
    end

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .fifo_mode_i (fifo_mode_i),
        .flush_i     (flush_i),
        .status_rd_i (status_rd_i),
        .wr_en_o     (wr_en),
        .wr_ptr_o    (wr_ptr),
        .rd_ptr_o    (rd_ptr),
        .count_o     (count),
        .overrun_o   (overrun_o)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_ptr_i   (wr_ptr),
        .wr_entry_i (wr_entry),
        .rd_ptr_i   (rd_ptr),
        .rd_entry_o (rd_entry)
    );

    rxq_head #(.DEPTH(DEPTH)) u_head (
        .entry_i (rd_entry),
        .count_i (count),
        .data_o  (head_data_o),
        .perr_o  (head_perr_o),
        .ferr_o  (head_ferr_o),
        .brk_o   (head_brk_o),
        .ready_o (data_ready_o)
    );

    assign level_o = count;
endmodule

// File: rtl/rxq_tagged_buf_chk.sv
// Property checker for rxq_tagged_buf, attached with bind below.
// Assumes the same DEPTH as the bound instance.
module rxq_tagged_buf_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic             fifo_mode_i,
    input logic             flush_i,
    input logic             status_rd_i,
    input logic [7:0]       head_data_o,
    input logic             head_perr_o,
    input logic             head_ferr_o,
    input logic             head_brk_o,
    input logic             data_ready_o,
    input logic             overrun_o,
    input logic [CNT_W-1:0] level_o
);
    localparam logic [CNT_W-1:0] FULL_L = CNT_W'(DEPTH);

    // R3: occupancy never exceeds the queue depth
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= FULL_L);

    // R2: character mode held for two cycles keeps at most one entry
    p_char_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode_i && !$past(fifo_mode_i)) |-> (level_o <= CNT_W'(1)));

    // R5: push into a full queue without pop raises overrun and keeps the level
    p_overrun_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !flush_i && fifo_mode_i && $past(fifo_mode_i) && level_o == FULL_L)
        |=> (overrun_o && level_o == FULL_L));

    // R6: push with pop at full keeps the level and reports no overrun
    p_full_pushpop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !flush_i && !status_rd_i && fifo_mode_i && $past(fifo_mode_i)
         && level_o == FULL_L)
        |=> (level_o == FULL_L && overrun_o == $past(overrun_o)));

    // R7: overrun is sticky without a status read
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !status_rd_i) |=> overrun_o);

    // R8: a mode change empties the buffer
    p_mode_change_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode_i != $past(fifo_mode_i)) |=> (level_o == '0));

    // R9: flush empties the buffer and drops data-ready
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (level_o == '0 && !data_ready_o));

    // R10: empty buffer shows zero head fields
    p_empty_head_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) |-> (head_data_o == 8'h00 && !head_perr_o && !head_ferr_o && !head_brk_o));

    // R10: pop alone on an empty buffer leaves it empty
    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && level_o == '0) |=> (level_o == '0));

    // R11: data-ready tracks a non-zero level
    p_ready_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready_o == (level_o != '0));
endmodule

bind rxq_tagged_buf rxq_tagged_buf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .fifo_mode_i  (fifo_mode_i),
    .flush_i      (flush_i),
    .status_rd_i  (status_rd_i),
    .head_data_o  (head_data_o),
    .head_perr_o  (head_perr_o),
    .head_ferr_o  (head_ferr_o),
    .head_brk_o   (head_brk_o),
    .data_ready_o (data_ready_o),
    .overrun_o    (overrun_o),
    .level_o      (level_o)
);

// File: tb/tb_rxq_tagged_buf.sv
// Bench for rxq_tagged_buf: behavioural queue model updated at each rising edge,
// all outputs compared at each falling edge. Inputs change 2 ns after the rising edge.
module tb_rxq_tagged_buf;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push = 1'b0, pop = 1'b0, mode = 1'b0, flush = 1'b0, srd = 1'b0;
    logic [7:0] pdata = 8'h00;
    logic [2:0] ptag = 3'b000;   // {perr, ferr, brk}

    logic [7:0]       head_data;
    logic             head_perr, head_ferr, head_brk, ready, ovr;
    logic [CNT_W-1:0] level;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    bit started = 0;
    bit done = 0;

    // model state: entries are {data, perr, ferr, brk}
    logic [10:0] mq[$];
    bit m_mode = 0;
    bit m_ovr = 0;

    always #5 clk = ~clk;

    rxq_tagged_buf #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .push_data_i(pdata),
        .push_perr_i(ptag[2]), .push_ferr_i(ptag[1]), .push_brk_i(ptag[0]),
        .pop_i(pop), .fifo_mode_i(mode), .flush_i(flush), .status_rd_i(srd),
        .head_data_o(head_data), .head_perr_o(head_perr), .head_ferr_o(head_ferr),
        .head_brk_o(head_brk), .data_ready_o(ready), .overrun_o(ovr), .level_o(level)
    );

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            mq.delete();
            m_mode = 0;
            m_ovr = 0;
        end else begin
            bit clr, full, dpop, dpush, oevt;
            int cap;
            clr   = flush || (mode != m_mode);
            cap   = m_mode ? DEPTH : 1;
            full  = (mq.size() == cap);
            dpop  = pop && (mq.size() > 0) && !clr;
            dpush = push && !clr && (!full || dpop);
            oevt  = push && !clr && full && !dpop;
            if (clr) mq.delete();
            else begin
                if (dpop) void'(mq.pop_front());
                if (dpush) mq.push_back({pdata, ptag});
            end
            if (oevt) m_ovr = 1;
            else if (srd) m_ovr = 0;
            m_mode = mode;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model at each falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            logic [10:0] h;
            h = (mq.size() > 0) ? mq[0] : 11'h0;
            chk("level", int'(level), mq.size());
            chk("data_ready", int'(ready), (mq.size() > 0) ? 1 : 0);
            chk("overrun", int'(ovr), int'(m_ovr));
            chk("head_data", int'(head_data), int'(h[10:3]));
            chk("head_tags", int'({head_perr, head_ferr, head_brk}), int'(h[2:0]));
        end
    end

    // One stimulus cycle: set inputs, then wait for the edge that samples them.
    task automatic cyc(input bit p, input logic [7:0] d, input logic [2:0] t,
                       input bit po, input bit fl, input bit sr);
        push = p; pdata = d; ptag = t; pop = po; flush = fl; srd = sr;
        @(posedge clk); #2;
        push = 0; pop = 0; flush = 0; srd = 0;
    endtask

    task automatic idle();
        cyc(0, 8'h00, 3'b000, 0, 0, 0);
    endtask

    // Watchdog.
    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234_5678;
        @(posedge clk); #2;
        @(posedge clk); #2;
        cur_req = "R1";                               // reset state
        chk("R1 level after reset", int'(level), 0);
        chk("R1 overrun after reset", int'(ovr), 0);
        rst_n = 1; idle();

        cur_req = "R2";                               // single holding register
        cyc(1, 8'hA5, 3'b100, 0, 0, 0);
        cyc(1, 8'h3C, 3'b011, 0, 0, 0);               // overrun, A5 kept
        chk("R2 head kept", int'(head_data), 8'hA5);
        chk("R2 overrun set", int'(ovr), 1);
        cur_req = "R6";
        cyc(1, 8'h77, 3'b010, 1, 0, 0);               // replace in char mode
        cur_req = "R7";
        idle();
        cyc(0, 8'h00, 3'b000, 0, 0, 1);               // clear overrun
        chk("R7 overrun cleared", int'(ovr), 0);
        cur_req = "R10";
        cyc(0, 8'h00, 3'b000, 1, 0, 0);
        cyc(0, 8'h00, 3'b000, 1, 0, 0);               // pop on empty
        chk("R10 empty head", int'(head_data), 0);

        cur_req = "R8";                               // switch to queue mode with push
        mode = 1;
        cyc(1, 8'h11, 3'b111, 0, 0, 0);
        chk("R8 push ignored on mode change", int'(level), 0);

        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) begin
            cur_req = (i % 2) ? "R4" : "R3";
            cyc(1, 8'(8'h20 + i), 3'(i), 0, 0, 0);
        end
        chk("R3 full level", int'(level), DEPTH);
        cur_req = "R5";
        cyc(1, 8'hEE, 3'b111, 0, 0, 0);
        chk("R5 head unchanged", int'(head_data), 8'h20);
        cur_req = "R6";
        cyc(1, 8'h99, 3'b101, 1, 0, 1);               // clears ovr, push accepted
        chk("R6 level stays full", int'(level), DEPTH);
        cur_req = "R7";
        cyc(1, 8'h98, 3'b001, 0, 0, 1);               // overrun beats read
        chk("R7 set wins", int'(ovr), 1);
        cur_req = "R3";
        for (int i = 0; i < DEPTH / 2; i++) cyc(0, 8'h00, 3'b000, 1, 0, 0);
        cur_req = "R9";
        cyc(1, 8'h55, 3'b110, 1, 1, 0);
        chk("R9 flushed", int'(level), 0);
        cur_req = "R8";
        for (int i = 0; i < 5; i++) cyc(1, 8'(8'h40 + i), 3'b000, 0, 0, 0);
        mode = 0;
        cyc(1, 8'h66, 3'b001, 1, 0, 0);
        chk("R8 emptied on return", int'(level), 0);

        cur_req = "R11";                              // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            seed = seed * 1103515245 + 12345;
            if (i % 150 == 0) mode = ~mode;
            cyc(seed[16], seed[31:24], seed[22:20], seed[17] & seed[18],
                (seed[15:10] == 0), seed[19] & seed[9]);
        end
        idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule